// File: doc/BRIEF.md
# Atomic Memory Read-Modify-Write Unit

This block carries out one atomic memory operation per request against a simple single-port memory. A request brings the effective address, a width code, an 8-bit operation code and the two register values involved (the source register and the fixed comparand/result register, called R0 here). The unit reads the addressed word and computes the new value. It then writes it back unless a compare-and-exchange finds a mismatch. Finally it returns the register writebacks the operation calls for. A lock output is held high for the whole read-compute-write window so that the memory side can keep other agents off the location.

The request and response sides are valid/ready streams. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle, so a new request waits until the previous response has been taken. The response is presented with `rsp_valid` and all response fields stay stable until a cycle where `rsp_ready` is also high. The memory port is plain request/ready: `mem_req` and its qualifiers stay constant until `mem_ready` is seen high at a clock edge. Read data is taken from `mem_rdata` in that same cycle.

Width code `req_size`: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. Operation codes: add 0x00, or 0x40, and 0x50, xor 0xa0, each optionally ORed with the fetch flag 0x01; exchange 0xe1; compare-and-exchange 0xf1.

Top module: `atomic_rmw_unit`

## Requirements
- R1: A request with width code 0 or 1 (8 or 16 bits) completes with `rsp_illegal` high, no memory access and no register writeback.
- R2: Codes 0x00/0x40/0x50/0xa0 (with or without 0x01) write old+src, old|src, old&src or old^src back to memory, wrapping at the operand width.
- R3: With the fetch flag 0x01 set on a simple operation, `src_wb_en` is high and `src_wb_data` is the pre-operation memory value; without it neither writeback enable is high.
- R4: Exchange 0xe1 stores src into memory and returns the old value on `src_wb_data` with `src_wb_en` high.
- R5: Compare-and-exchange 0xf1 with memory equal to R0 stores src; `r0_wb_en` is high with the old value and `src_wb_en` is low.
- R6: Compare-and-exchange with memory not equal to R0 makes no memory write but still returns the old value on `r0_wb_data`.
- R7: Any other operation code (including 0xe0 and 0xf0) completes with `rsp_illegal` high, no memory access and no writeback.
- R8: A 32-bit operation uses only bits 31:0 of src, R0 and memory, drives `mem_wide` low with `mem_wdata[63:32]` zero, and returns values zero-extended to 64 bits.
- R9: `mem_lock` is high whenever `mem_req` is high and for every cycle from the read request through the write completion; it is low while a response is presented.
- R10: Each legal operation makes exactly one read followed by at most one write; the response is held stable while `rsp_ready` is low, and `req_ready` is low until it is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_addr | input | ADDR_W | Effective address |
| req_size | input | 2 | Width code |
| req_op | input | 8 | Operation code |
| req_src | input | 64 | Source register value |
| req_r0 | input | 64 | Comparand register value |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_illegal | output | 1 | Request was rejected |
| src_wb_en | output | 1 | Write `src_wb_data` to the source register |
| src_wb_data | output | 64 | Value for the source register |
| r0_wb_en | output | 1 | Write `r0_wb_data` to R0 |
| r0_wb_data | output | 64 | Value for R0 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_wide | output | 1 | Access is 64-bit (low = 32-bit, bits 31:0) |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | 64 | Write data |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_rdata | input | 64 | Read data, valid with `mem_ready` on a read |
| mem_lock | output | 1 | Location is held for the atomic sequence |

## Verification
A wrong state in the sequencer shows at the memory port within the operation that caused it. Examples are a second read, a write after a failed compare, a write without the lock held, or an access for a rejected request. A bad captured width or operation shows as a wrong memory word or writeback value in the same response. The scoreboard checks both the returned registers and the memory word against a model of each operation. A stuck response or a dropped handshake is caught by the response hold check or by the watchdog.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int DATA_W = 64;
  localparam int HALF_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_COMPUTE, ST_WRITE, ST_DONE
  } amo_state_e;

  typedef enum logic [2:0] {
    K_ADD, K_OR, K_AND, K_XOR, K_XCHG, K_CMPX
  } amo_kind_e;

  localparam logic [7:0] OP_ADD  = 8'h00;
  localparam logic [7:0] OP_OR   = 8'h40;
  localparam logic [7:0] OP_AND  = 8'h50;
  localparam logic [7:0] OP_XOR  = 8'ha0;
  localparam logic [7:0] OP_XCHG = 8'he1;
  localparam logic [7:0] OP_CMPX = 8'hf1;
  localparam logic [7:0] FETCH   = 8'h01;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
(
  input  logic [7:0] op,
  input  logic [1:0] size,
  output logic       legal,
  output logic       wide,
  output logic       fetch,
  output amo_kind_e  kind
);
  logic op_ok;

  always_comb begin
    op_ok = 1'b1;
    kind  = K_ADD;
    unique case (op)
      OP_ADD, OP_ADD | FETCH: kind = K_ADD;
      OP_OR,  OP_OR  | FETCH: kind = K_OR;
      OP_AND, OP_AND | FETCH: kind = K_AND;
      OP_XOR, OP_XOR | FETCH: kind = K_XOR;
      OP_XCHG:                kind = K_XCHG;
      OP_CMPX:                kind = K_CMPX;
      default:                op_ok = 1'b0;
    endcase
  end

  // width codes 2 (32-bit) and 3 (64-bit) are the only accepted ones
  assign legal = op_ok & size[1];
  assign wide  = (size == 2'd3);
  assign fetch = op[0];
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
(
  input  amo_kind_e         kind,
  input  logic              wide,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] cmp_val,
  output logic [DATA_W-1:0] new_val,
  output logic              do_write
);
  logic [DATA_W-1:0] raw;
  logic              match;

  always_comb begin
    unique case (kind)
      K_ADD:   raw = old_val + src_val;
      K_OR:    raw = old_val | src_val;
      K_AND:   raw = old_val & src_val;
      K_XOR:   raw = old_val ^ src_val;
      default: raw = src_val;
    endcase
  end

  assign match    = wide ? (old_val == cmp_val)
                         : (old_val[HALF_W-1:0] == cmp_val[HALF_W-1:0]);
  assign new_val  = wide ? raw : {{(DATA_W-HALF_W){1'b0}}, raw[HALF_W-1:0]};
  assign do_write = (kind != K_CMPX) | match;
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [7:0]        req_op,
  input  logic [63:0]       req_src,
  input  logic [63:0]       req_r0,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_illegal,
  output logic              src_wb_en,
  output logic [63:0]       src_wb_data,
  output logic              r0_wb_en,
  output logic [63:0]       r0_wb_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [63:0]       mem_rdata,
  output logic              mem_lock
);
  localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  amo_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic              wide_q, fetch_q, illegal_q, wr_q;
  amo_kind_e         kind_q;
  logic [DATA_W-1:0] src_q, r0_q, old_q, new_q;

  logic              dec_legal, dec_wide, dec_fetch;
  amo_kind_e         dec_kind;
  logic [DATA_W-1:0] alu_new;
  logic              alu_write;

  amo_decode u_decode (
    .op(req_op), .size(req_size), .legal(dec_legal),
    .wide(dec_wide), .fetch(dec_fetch), .kind(dec_kind)
  );

  amo_alu u_alu (
    .kind(kind_q), .wide(wide_q), .old_val(old_q), .src_val(src_q),
    .cmp_val(r0_q), .new_val(alu_new), .do_write(alu_write)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      wide_q    <= 1'b0;
      fetch_q   <= 1'b0;
      illegal_q <= 1'b0;
      wr_q      <= 1'b0;
      kind_q    <= K_ADD;
      src_q     <= '0;
      r0_q      <= '0;
      old_q     <= '0;
      new_q     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          addr_q    <= req_addr;
          wide_q    <= dec_wide;
          fetch_q   <= dec_fetch;
          kind_q    <= dec_kind;
          illegal_q <= !dec_legal;
          src_q     <= dec_wide ? req_src : (req_src & LOW_MASK);
          r0_q      <= dec_wide ? req_r0  : (req_r0  & LOW_MASK);
          state     <= dec_legal ? ST_READ : ST_DONE;
        end
        ST_READ: if (mem_ready) begin
          old_q <= wide_q ? mem_rdata : (mem_rdata & LOW_MASK);
          state <= ST_COMPUTE;
        end
        ST_COMPUTE: begin
          new_q <= alu_new;
          wr_q  <= alu_write;
          state <= alu_write ? ST_WRITE : ST_DONE;
        end
        ST_WRITE: if (mem_ready) state <= ST_DONE;
        ST_DONE:  if (rsp_ready) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign rsp_valid   = (state == ST_DONE);
  assign rsp_illegal = rsp_valid & illegal_q;
  assign src_wb_en   = rsp_valid & !illegal_q & fetch_q & (kind_q != K_CMPX);
  assign r0_wb_en    = rsp_valid & !illegal_q & (kind_q == K_CMPX);
  assign src_wb_data = src_wb_en ? old_q : '0;
  assign r0_wb_data  = r0_wb_en  ? old_q : '0;

  assign mem_req   = (state == ST_READ) | (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_wide  = wide_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = new_q;
  assign mem_lock  = (state == ST_READ) | (state == ST_COMPUTE) | (state == ST_WRITE);

  AST_LOCK_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock) else $error("lock low during access"); // R9

  AST_LOCK_OFF_AT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_lock && !mem_req) else $error("lock held at response"); // R9

  AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> !src_wb_en && !r0_wb_en) else $error("writeback on illegal"); // R7

  AST_ILLEGAL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_q && state != ST_IDLE) |-> !mem_req) else $error("access on illegal"); // R1

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(src_wb_data) && $stable(r0_wb_data)
      && $stable(src_wb_en) && $stable(r0_wb_en) && $stable(rsp_illegal))
    else $error("response changed under back-pressure"); // R10

  AST_WRITE_AFTER_COMPUTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(state) == ST_COMPUTE) else $error("write without read"); // R10

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_wide) |-> mem_wdata[63:32] == 32'd0)
    else $error("upper half set on 32-bit write"); // R8

  AST_CMPX_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COMPUTE && kind_q == K_CMPX &&
     (wide_q ? old_q != r0_q : old_q[31:0] != r0_q[31:0])) |=> !mem_we)
    else $error("write after failed compare"); // R6
endmodule

// File: tb/atomic_rmw_unit_bench.sv
module atomic_rmw_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;

  typedef struct {
    logic        illegal;
    logic        src_en;
    logic [63:0] src_val;
    logic        r0_en;
    logic [63:0] r0_val;
    int          idx;
    logic [63:0] mem_after;
    int          reads;
    int          writes;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [7:0] req_op = '0;
  logic [63:0] req_src = '0, req_r0 = '0;
  logic rsp_valid, rsp_ready, rsp_illegal, src_wb_en, r0_wb_en;
  logic [63:0] src_wb_data, r0_wb_data;
  logic mem_req, mem_we, mem_wide, mem_ready, mem_lock;
  logic [ADDR_W-1:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;

  logic [63:0] mem [16];
  int cyc = 0, checks = 0, failures = 0, rd_cnt = 0, wr_cnt = 0;
  int rd_base = 0, wr_base = 0, lock_bad = 0, done_cnt = 0;
  logic mem_stall = 1'b0, finished = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  atomic_rmw_unit #(.ADDR_W(ADDR_W)) u_atomic_rmw_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_op(req_op),
    .req_src(req_src), .req_r0(req_r0), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_illegal(rsp_illegal), .src_wb_en(src_wb_en),
    .src_wb_data(src_wb_data), .r0_wb_en(r0_wb_en), .r0_wb_data(r0_wb_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .mem_lock(mem_lock)
  );

  // memory model and back-pressure patterns
  assign mem_ready = mem_req & !mem_stall;
  assign mem_rdata = mem[mem_addr[6:3]];
  initial rsp_ready = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_stall <= (cyc % 4) == 1;
    rsp_ready <= (cyc % 3) != 0;
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        wr_cnt <= wr_cnt + 1;
        if (mem_wide) mem[mem_addr[6:3]] <= mem_wdata;
        else mem[mem_addr[6:3]][31:0] <= mem_wdata[31:0];
      end else rd_cnt <= rd_cnt + 1;
    end
    if (mem_req && !mem_lock) lock_bad <= lock_bad + 1;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // independent model of one operation
  function automatic exp_t model(input logic [7:0] op, input logic [1:0] size,
                                 input int idx, input logic [63:0] src,
                                 input logic [63:0] r0, input string tag);
    exp_t e;
    logic w; logic [63:0] m, o, s, r, nv; logic wr, legal_op;
    m = mem[idx]; w = (size == 2'd3);
    o = w ? m : {32'd0, m[31:0]};
    s = w ? src : {32'd0, src[31:0]};
    r = w ? r0 : {32'd0, r0[31:0]};
    legal_op = 1'b1; wr = 1'b1; nv = '0;
    case (op)
      8'h00, 8'h01: nv = o + s;
      8'h40, 8'h41: nv = o | s;
      8'h50, 8'h51: nv = o & s;
      8'ha0, 8'ha1: nv = o ^ s;
      8'he1: nv = s;
      8'hf1: begin nv = s; wr = (o == r); end
      default: legal_op = 1'b0;
    endcase
    e.tag = tag; e.idx = idx;
    e.illegal = !(legal_op && size >= 2);
    e.src_en = !e.illegal && op[0] && op != 8'hf1;
    e.r0_en = !e.illegal && op == 8'hf1;
    e.src_val = e.src_en ? o : '0;
    e.r0_val = e.r0_en ? o : '0;
    e.reads = e.illegal ? 0 : 1;
    e.writes = (e.illegal || !wr) ? 0 : 1;
    if (e.writes == 0) e.mem_after = m;
    else e.mem_after = w ? nv : {m[63:32], nv[31:0]};
    return e;
  endfunction

  task automatic issue(input logic [7:0] op, input logic [1:0] size, input int idx,
                       input logic [63:0] src, input logic [63:0] r0, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    q.push_back(model(op, size, idx, src, r0, tag));
    req_valid = 1'b1; req_op = op; req_size = size;
    req_addr = ADDR_W'(idx * 8); req_src = src; req_r0 = r0;
    @(negedge clk);
    req_valid = 1'b0; req_op = 8'h5a; req_src = '1; req_r0 = '1;
  endtask

  // monitor: scoreboard pop and response hold check
  logic        hold_pend = 1'b0;
  logic [63:0] hold_src, hold_r0;
  always @(negedge clk) if (rst_n) begin
    if (hold_pend) begin
      check("R10 hold valid", {63'd0, rsp_valid}, 64'd1);
      check("R10 hold src", src_wb_data, hold_src);
      check("R10 hold r0", r0_wb_data, hold_r0);
      hold_pend = 1'b0;
    end
    if (rsp_valid && !rsp_ready) begin
      hold_pend = 1'b1; hold_src = src_wb_data; hold_r0 = r0_wb_data;
      check("R10 req_ready low while response pending", {63'd0, req_ready}, 64'd0);
    end
    if (rsp_valid && rsp_ready) begin
      exp_t e;
      if (q.size() == 0) begin
        check("R10 unexpected response", 64'd1, 64'd0);
      end else begin
        e = q.pop_front();
        check({e.tag, " illegal"}, {63'd0, rsp_illegal}, {63'd0, e.illegal});
        check({e.tag, " src_en"}, {63'd0, src_wb_en}, {63'd0, e.src_en});
        check({e.tag, " src_data"}, src_wb_data, e.src_val);
        check({e.tag, " r0_en"}, {63'd0, r0_wb_en}, {63'd0, e.r0_en});
        check({e.tag, " r0_data"}, r0_wb_data, e.r0_val);
        check({e.tag, " mem"}, mem[e.idx], e.mem_after);
        check({e.tag, " reads (R10)"}, 64'(rd_cnt - rd_base), 64'(e.reads));
        check({e.tag, " writes (R10)"}, 64'(wr_cnt - wr_base), 64'(e.writes));
        check({e.tag, " R9 lock low at response"}, {63'd0, mem_lock}, 64'd0);
      end
      rd_base = rd_cnt; wr_base = wr_cnt; done_cnt++;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 64'h0101_0101_0000_0000 * 64'(i + 1) + 64'(i);
    mem[1] = 64'hAAAA_AAAA_FFFF_FFF0;
    mem[6] = 64'h0000_0000_CAFE_F00D;
    mem[7] = 64'h5555_5555_1234_5678;
    repeat (3) @(negedge clk);
    check("reset req_ready", {63'd0, req_ready}, 64'd1);
    check("reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check("reset mem_req", {63'd0, mem_req}, 64'd0);
    check("R9 reset mem_lock", {63'd0, mem_lock}, 64'd0);
    rst_n = 1'b1;

    issue(8'h00, 2'd3, 0, 64'h0000_0001_0000_0005, 64'd0, "R2 add64 nofetch R3");
    issue(8'h01, 2'd2, 1, 64'h1234_5678_0000_0020, 64'd0, "R2 add32 fetch wrap R8");
    issue(8'h41, 2'd3, 2, 64'hF000_0000_0000_000F, 64'd0, "R3 or64 fetch");
    issue(8'h50, 2'd3, 3, 64'h00FF_00FF_00FF_00FF, 64'd0, "R2 and64 nofetch");
    issue(8'ha1, 2'd2, 4, 64'hFFFF_FFFF_0F0F_0F0F, 64'd0, "R3 xor32 fetch R8");
    issue(8'he1, 2'd3, 5, 64'hDEAD_BEEF_0BAD_F00D, 64'd0, "R4 xchg64");
    issue(8'he1, 2'd2, 7, 64'h9999_9999_8765_4321, 64'd0, "R4 xchg32 R8");
    issue(8'hf1, 2'd3, 6, 64'h1111_2222_3333_4444, 64'h0000_0000_CAFE_F00D, "R5 cmpx64 equal");
    issue(8'hf1, 2'd3, 8, 64'h7777, 64'h1, "R6 cmpx64 mismatch");
    issue(8'hf1, 2'd2, 9, 64'hABCD_0000_5A5A_5A5A, {32'hFFFF_FFFF, mem[9][31:0]}, "R5 cmpx32 equal R8");
    issue(8'hf1, 2'd2, 10, 64'h1, {mem[10][31:0], mem[10][31:0] ^ 32'h1}, "R6 cmpx32 mismatch");
    issue(8'h00, 2'd0, 11, 64'h1, 64'd0, "R1 width8 rejected");
    issue(8'h01, 2'd1, 11, 64'h1, 64'd0, "R1 width16 rejected");
    issue(8'he0, 2'd3, 12, 64'h1, 64'd0, "R7 xchg without fetch");
    issue(8'hf0, 2'd3, 12, 64'h1, 64'd0, "R7 cmpx without fetch");
    issue(8'h10, 2'd3, 12, 64'h1, 64'd0, "R7 unknown op");
    issue(8'h51, 2'd2, 13, 64'h0000_0001_FFFF_0000, 64'd0, "R3 and32 fetch R8");

    while (done_cnt < 17) @(negedge clk);
    check("R9 lock high with every access", 64'(lock_bad), 64'd0);
    check("R10 scoreboard drained", 64'(q.size()), 64'd0);
    finish_run();
  end

  initial begin
    while (cyc < 20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog act=%0d expected_done=17 done=%0d", cyc, done_cnt);
    finish_run();
  end
endmodule